// File: doc/BRIEF.md
# Chip Operating Mode Clock Controller

This block follows the operating mode of a small processor chip and drives the reset lines and clock enables for the processor core, the memories and the peripheral groups. It also drives the watchdog enable, the PWM output disable and the CAN clock enable. The sources it listens to are a system reset request, a request to hold only the core in reset, a flash-loader completion flag, a debug request, the wait and stop instructions issued by the core, and wake sources: a CAN wake line and a vector of interrupts with a per-line enable mask. Option bits pick how the watchdog, the PWM outputs and the CAN clock behave in debug, wait and stop.

Clock gating is modelled as registered enable signals. Every output is a register, so each one changes one clock after the inputs that caused it are sampled. A 3-bit mode status and a one-cycle core-release pulse are brought out so that the mode sequence can be observed from outside.

Top module: `opmode_clk_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `mode_o` is 0, `core_rst` and `periph_rst` are 1, every clock enable, `wdog_en`, `pll_off` and `sync_pulse` are 0, and `pwm_dis` is 1.
- R2: A high `sys_rst_req` in any mode makes `mode_o` equal 0 (total reset: core and peripherals reset, all clocks off) one cycle later. One cycle after `sys_rst_req` falls, the mode is 1.
- R3: Mode 1 (core-only reset) drives `core_rst`=1, `periph_rst`=0, `periph_clk_en`=1, `can_clk_en`=1, and `core_clk_en`=`mem_clk_en`=`wdog_en`=0, with `pwm_dis`=1. The mode stays 1 until `flash_done` is 1 and `core_rst_req` is 0. `core_rst_req`=1 moves any mode to 1 unless `sys_rst_req` is also high.
- R4: Mode 2 (run) releases both resets and sets all clock enables and `wdog_en` to 1, with `pwm_dis`=0. `sync_pulse` is high for exactly the first cycle of run that follows mode 1.
- R5: `dbg_req` in run goes to mode 3 (debug) even when `wait_req` or `stop_req` is also high. Debug keeps every clock on, forces `wdog_en`=0 and sets `pwm_dis` to `cfg_dbg_pwm_off`. It returns to run one cycle after `dbg_req` falls.
- R6: `wait_req` in run goes to mode 4 (wait), unless `stop_req` is also high, in which case stop wins. Wait turns off `core_clk_en` and `mem_clk_en` and keeps `periph_clk_en` and `can_clk_en` on. It sets `wdog_en` to the inverse of `cfg_wait_wdog_stop` and `pwm_dis` to `cfg_wait_pwm_off`.
- R7: `stop_req` in run goes to mode 5 (stop). Stop turns off the core, memory and peripheral clock enables and sets `pwm_dis`=1. It sets `wdog_en` to the inverse of `cfg_stop_wdog_stop` and `can_clk_en` to the inverse of `cfg_stop_can_stop`.
- R8: `pll_off` is 1 only in mode 5 with `cfg_pll_pdn`=1. Entering stop with `cfg_pll_pdn`=0 leaves it 0.
- R9: In stop, a wake is a high `can_wake`, any `irq_pend` bit whose `irq_mask` bit is 1, or `dbg_req`. In wait, a wake is an unmasked interrupt or `dbg_req`, and `can_wake` is ignored. Interrupts whose mask bit is 0 never wake.
- R10: A wake from wait or stop passes through mode 6 (only `mem_clk_en` of the core/memory pair on) and then mode 7 (`mem_clk_en` and `core_clk_en` on). Both wake modes have the peripheral and CAN clocks on, `wdog_en`=1 and `pwm_dis`=0. The block enters run on the next cycle. `core_clk_en` is never 1 while `mem_clk_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the controller |
| sys_rst_req | input | 1 | System (total) reset request |
| core_rst_req | input | 1 | Request to hold only the core in reset |
| flash_done | input | 1 | Flash loader has finished filling its registers |
| dbg_req | input | 1 | Debug request, level |
| wait_req | input | 1 | Wait instruction from core |
| stop_req | input | 1 | Stop instruction from core |
| can_wake | input | 1 | CAN wake line |
| irq_pend | input | N_IRQ | Pending interrupt lines |
| irq_mask | input | N_IRQ | Interrupt wake enables, 1 = may wake |
| cfg_dbg_pwm_off | input | 1 | Disable PWM outputs in debug |
| cfg_wait_wdog_stop | input | 1 | Stop watchdog in wait |
| cfg_wait_pwm_off | input | 1 | Disable PWM outputs in wait |
| cfg_stop_wdog_stop | input | 1 | Stop watchdog in stop |
| cfg_stop_can_stop | input | 1 | Stop CAN clock in stop |
| cfg_pll_pdn | input | 1 | Software PLL power-down request, applied only in stop |
| core_rst | output | 1 | Core reset |
| periph_rst | output | 1 | Peripheral reset |
| core_clk_en | output | 1 | Core clock enable |
| mem_clk_en | output | 1 | Memory clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| wdog_en | output | 1 | Watchdog enable |
| pwm_dis | output | 1 | PWM output disable |
| can_clk_en | output | 1 | CAN clock enable |
| pll_off | output | 1 | PLL power-down |
| sync_pulse | output | 1 | One-cycle pulse on core release into run |
| mode_o | output | 3 | Current mode code (0 to 7 as in the requirements) |

## Verification
The mode sequence is driven through reset release with `flash_done` held low and then raised, and through debug requests that arrive together with wait and stop. This separates the hold in core-only reset and the debug-over-sleep priority from the plain order of the transitions. Wait and stop are entered with the option bits set differently each time, so a swapped or inverted option shows up in the gate outputs. Each sleep mode is then offered masked interrupts, CAN wake and unmasked interrupts, which tells apart the wake sources that each mode accepts and checks the memory-then-core restart. System and core-only reset requests are raised from run and from stop to test their priority.

// File: rtl/opmode_pkg.sv
package opmode_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    M_TOTAL_RST = 3'd0,
    M_CORE_RST  = 3'd1,
    M_RUN       = 3'd2,
    M_DEBUG     = 3'd3,
    M_WAIT      = 3'd4,
    M_STOP      = 3'd5,
    M_WAKE_MEM  = 3'd6,
    M_WAKE_CORE = 3'd7
  } mode_e;

  typedef struct packed {
    logic dbg_pwm_off;
    logic wait_wdog_stop;
    logic wait_pwm_off;
    logic stop_wdog_stop;
    logic stop_can_stop;
    logic pll_pdn;
  } cfg_t;

  typedef struct packed {
    logic core_rst;
    logic periph_rst;
    logic core_clk_en;
    logic mem_clk_en;
    logic periph_clk_en;
    logic wdog_en;
    logic pwm_dis;
    logic can_clk_en;
    logic pll_off;
  } gate_t;

  localparam gate_t GATE_RESET = '{core_rst: 1'b1, periph_rst: 1'b1, core_clk_en: 1'b0,
                                   mem_clk_en: 1'b0, periph_clk_en: 1'b0, wdog_en: 1'b0,
                                   pwm_dis: 1'b1, can_clk_en: 1'b0, pll_off: 1'b0};

  function automatic gate_t gate_for(mode_e m, cfg_t c);
    gate_t g;
    g = GATE_RESET;
    case (m)
      M_TOTAL_RST: g = GATE_RESET;
      M_CORE_RST: begin
        g.periph_rst    = 1'b0;
        g.periph_clk_en = 1'b1;
        g.can_clk_en    = 1'b1;
      end
      M_RUN: begin
        g.core_rst      = 1'b0;
        g.periph_rst    = 1'b0;
        g.core_clk_en   = 1'b1;
        g.mem_clk_en    = 1'b1;
        g.periph_clk_en = 1'b1;
        g.wdog_en       = 1'b1;
        g.pwm_dis       = 1'b0;
        g.can_clk_en    = 1'b1;
      end
      M_DEBUG: begin
        g.core_rst      = 1'b0;
        g.periph_rst    = 1'b0;
        g.core_clk_en   = 1'b1;
        g.mem_clk_en    = 1'b1;
        g.periph_clk_en = 1'b1;
        g.wdog_en       = 1'b0;
        g.pwm_dis       = c.dbg_pwm_off;
        g.can_clk_en    = 1'b1;
      end
      M_WAIT: begin
        g.core_rst      = 1'b0;
        g.periph_rst    = 1'b0;
        g.periph_clk_en = 1'b1;
        g.wdog_en       = ~c.wait_wdog_stop;
        g.pwm_dis       = c.wait_pwm_off;
        g.can_clk_en    = 1'b1;
      end
      M_STOP: begin
        g.core_rst      = 1'b0;
        g.periph_rst    = 1'b0;
        g.wdog_en       = ~c.stop_wdog_stop;
        g.pwm_dis       = 1'b1;
        g.can_clk_en    = ~c.stop_can_stop;
        g.pll_off       = c.pll_pdn;
      end
      M_WAKE_MEM, M_WAKE_CORE: begin
        g.core_rst      = 1'b0;
        g.periph_rst    = 1'b0;
        g.core_clk_en   = (m == M_WAKE_CORE);
        g.mem_clk_en    = 1'b1;
        g.periph_clk_en = 1'b1;
        g.wdog_en       = 1'b1;
        g.pwm_dis       = 1'b0;
        g.can_clk_en    = 1'b1;
      end
      default: g = GATE_RESET;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/opmode_wake.sv
module opmode_wake #(
  parameter int N_IRQ = 8
) (
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_mask,
  input  logic             can_wake,
  input  logic             dbg_req,
  output logic             wake_wait,
  output logic             wake_stop
);
  logic [N_IRQ-1:0] irq_live;
  logic             any_irq;

  genvar i;
  generate
    for (i = 0; i < N_IRQ; i++) begin : g_mask
      assign irq_live[i] = irq_pend[i] & irq_mask[i];
    end
  endgenerate

  assign any_irq   = |irq_live;
  // wait ignores the CAN line; stop accepts it (R9)
  assign wake_wait = any_irq | dbg_req;
  assign wake_stop = any_irq | dbg_req | can_wake;
endmodule

// File: rtl/opmode_fsm.sv
module opmode_fsm
  import opmode_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sys_rst_req,
  input  logic  core_rst_req,
  input  logic  flash_done,
  input  logic  dbg_req,
  input  logic  wait_req,
  input  logic  stop_req,
  input  logic  wake_wait,
  input  logic  wake_stop,
  output mode_e state_d,
  output mode_e state_q
);
  always_comb begin
    state_d = state_q;
    if (sys_rst_req) begin
      state_d = M_TOTAL_RST;
    end else if (core_rst_req) begin
      state_d = M_CORE_RST;
    end else begin
      case (state_q)
        M_TOTAL_RST: state_d = M_CORE_RST;
        M_CORE_RST:  if (flash_done) state_d = M_RUN;
        M_RUN: begin
          if (dbg_req)       state_d = M_DEBUG;
          else if (stop_req) state_d = M_STOP;
          else if (wait_req) state_d = M_WAIT;
        end
        M_DEBUG:     if (!dbg_req) state_d = M_RUN;
        M_WAIT:      if (wake_wait) state_d = M_WAKE_MEM;
        M_STOP:      if (wake_stop) state_d = M_WAKE_MEM;
        M_WAKE_MEM:  state_d = M_WAKE_CORE;
        M_WAKE_CORE: state_d = M_RUN;
        default:     state_d = M_TOTAL_RST;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= M_TOTAL_RST;
    else     state_q <= state_d;
  end

  p_total_prio_r2: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |=> state_q == M_TOTAL_RST);

  p_core_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == M_CORE_RST && !flash_done && !sys_rst_req) |=> state_q == M_CORE_RST);

  p_dbg_prio_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == M_RUN && dbg_req && !sys_rst_req && !core_rst_req) |=> state_q == M_DEBUG);

  p_wake_seq_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == M_WAKE_MEM && !sys_rst_req && !core_rst_req) |=> state_q == M_WAKE_CORE);
endmodule

// File: rtl/opmode_gate.sv
module opmode_gate
  import opmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  mode_e             state_d,
  input  mode_e             state_q,
  input  cfg_t              cfg,
  output gate_t             gate_q,
  output logic              pulse_q,
  output logic [MODE_W-1:0] mode_q
);
  gate_t gate_d;
  logic  pulse_d;

  assign gate_d  = gate_for(state_d, cfg);
  assign pulse_d = (state_q == M_CORE_RST) && (state_d == M_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q  <= GATE_RESET;
      pulse_q <= 1'b0;
      mode_q  <= M_TOTAL_RST;
    end else begin
      gate_q  <= gate_d;
      pulse_q <= pulse_d;
      mode_q  <= state_d;
    end
  end

  p_dbg_wdog_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_DEBUG) |-> !gate_q.wdog_en);

  p_pll_stop_r8: assert property (@(posedge clk) disable iff (rst)
    gate_q.pll_off |-> (mode_q == M_STOP));

  p_mem_before_core_r10: assert property (@(posedge clk) disable iff (rst)
    gate_q.core_clk_en |-> gate_q.mem_clk_en);

  p_pulse_once_r4: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);
endmodule

// File: rtl/opmode_clk_ctrl.sv
module opmode_clk_ctrl
  import opmode_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sys_rst_req,
  input  logic             core_rst_req,
  input  logic             flash_done,
  input  logic             dbg_req,
  input  logic             wait_req,
  input  logic             stop_req,
  input  logic             can_wake,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_mask,
  input  logic             cfg_dbg_pwm_off,
  input  logic             cfg_wait_wdog_stop,
  input  logic             cfg_wait_pwm_off,
  input  logic             cfg_stop_wdog_stop,
  input  logic             cfg_stop_can_stop,
  input  logic             cfg_pll_pdn,
  output logic             core_rst,
  output logic             periph_rst,
  output logic             core_clk_en,
  output logic             mem_clk_en,
  output logic             periph_clk_en,
  output logic             wdog_en,
  output logic             pwm_dis,
  output logic             can_clk_en,
  output logic             pll_off,
  output logic             sync_pulse,
  output logic [2:0]       mode_o
);
  logic  wake_wait, wake_stop;
  mode_e state_d, state_q;
  cfg_t  cfg;
  gate_t gate_q;

  assign cfg = '{dbg_pwm_off: cfg_dbg_pwm_off, wait_wdog_stop: cfg_wait_wdog_stop,
                 wait_pwm_off: cfg_wait_pwm_off, stop_wdog_stop: cfg_stop_wdog_stop,
                 stop_can_stop: cfg_stop_can_stop, pll_pdn: cfg_pll_pdn};

  opmode_wake #(.N_IRQ(N_IRQ)) u_wake (
    .irq_pend (irq_pend),
    .irq_mask (irq_mask),
    .can_wake (can_wake),
    .dbg_req  (dbg_req),
    .wake_wait(wake_wait),
    .wake_stop(wake_stop)
  );

  opmode_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .sys_rst_req (sys_rst_req),
    .core_rst_req(core_rst_req),
    .flash_done  (flash_done),
    .dbg_req     (dbg_req),
    .wait_req    (wait_req),
    .stop_req    (stop_req),
    .wake_wait   (wake_wait),
    .wake_stop   (wake_stop),
    .state_d     (state_d),
    .state_q     (state_q)
  );

  opmode_gate u_gate (
    .clk    (clk),
    .rst    (rst),
    .state_d(state_d),
    .state_q(state_q),
    .cfg    (cfg),
    .gate_q (gate_q),
    .pulse_q(sync_pulse),
    .mode_q (mode_o)
  );

  assign core_rst      = gate_q.core_rst;
  assign periph_rst    = gate_q.periph_rst;
  assign core_clk_en   = gate_q.core_clk_en;
  assign mem_clk_en    = gate_q.mem_clk_en;
  assign periph_clk_en = gate_q.periph_clk_en;
  assign wdog_en       = gate_q.wdog_en;
  assign pwm_dis       = gate_q.pwm_dis;
  assign can_clk_en    = gate_q.can_clk_en;
  assign pll_off       = gate_q.pll_off;
endmodule

// File: tb/tb_opmode_clk_ctrl.sv
`timescale 1ns/1ps
module tb_opmode_clk_ctrl;
  localparam int N = 8;
  logic clk = 1'b0, rst = 1'b1;
  logic sys_rst_req = 1'b1, core_rst_req = 1'b0, flash_done = 1'b0, dbg_req = 1'b0;
  logic wait_req = 1'b0, stop_req = 1'b0, can_wake = 1'b0;
  logic [N-1:0] irq_pend = '0, irq_mask = '0;
  logic c_dpwm = 0, c_wwd = 0, c_wpwm = 0, c_swd = 0, c_scan = 0, c_pll = 0;
  logic core_rst, periph_rst, core_clk_en, mem_clk_en, periph_clk_en, wdog_en;
  logic pwm_dis, can_clk_en, pll_off, sync_pulse;
  logic [2:0] mode_o;

  always #5 clk = ~clk;

  opmode_clk_ctrl #(.N_IRQ(N)) dut (
    .clk(clk), .rst(rst), .sys_rst_req(sys_rst_req), .core_rst_req(core_rst_req),
    .flash_done(flash_done), .dbg_req(dbg_req), .wait_req(wait_req), .stop_req(stop_req),
    .can_wake(can_wake), .irq_pend(irq_pend), .irq_mask(irq_mask),
    .cfg_dbg_pwm_off(c_dpwm), .cfg_wait_wdog_stop(c_wwd), .cfg_wait_pwm_off(c_wpwm),
    .cfg_stop_wdog_stop(c_swd), .cfg_stop_can_stop(c_scan), .cfg_pll_pdn(c_pll),
    .core_rst(core_rst), .periph_rst(periph_rst), .core_clk_en(core_clk_en),
    .mem_clk_en(mem_clk_en), .periph_clk_en(periph_clk_en), .wdog_en(wdog_en),
    .pwm_dis(pwm_dis), .can_clk_en(can_clk_en), .pll_off(pll_off),
    .sync_pulse(sync_pulse), .mode_o(mode_o));

  int n_checks = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // reference model: mode number and config snapshot taken at each edge
  int m_mode = 0;
  bit m_pulse = 0;
  bit [5:0] m_cfg = '0;

  function automatic bit [12:0] expect_vec(int m, bit [5:0] c, bit p);
    bit cr, pr, cc, mc, pc, wd, pw, cn, pl;
    // c = {dpwm, wwd, wpwm, swd, scan, pll}
    cr = 0; pr = 0; cc = 0; mc = 0; pc = 0; wd = 0; pw = 0; cn = 0; pl = 0;
    if (m == 0) begin cr = 1; pr = 1; pw = 1; end
    else if (m == 1) begin cr = 1; pc = 1; cn = 1; pw = 1; end
    else if (m == 2) begin cc = 1; mc = 1; pc = 1; wd = 1; cn = 1; end
    else if (m == 3) begin cc = 1; mc = 1; pc = 1; cn = 1; pw = c[5]; end
    else if (m == 4) begin pc = 1; cn = 1; wd = !c[4]; pw = c[3]; end
    else if (m == 5) begin wd = !c[2]; cn = !c[1]; pw = 1; pl = c[0]; end
    else begin mc = 1; cc = (m == 7); pc = 1; wd = 1; cn = 1; end
    return {cr, pr, cc, mc, pc, wd, pw, cn, pl, p, m[2:0]};
  endfunction

  always @(posedge clk) begin
    int nx;
    if (rst) begin
      m_mode <= 0; m_pulse <= 0;
    end else begin
      nx = m_mode;
      if (sys_rst_req) nx = 0;
      else if (core_rst_req) nx = 1;
      else if (m_mode == 0) nx = 1;
      else if (m_mode == 1) begin if (flash_done) nx = 2; end
      else if (m_mode == 2) begin
        if (dbg_req) nx = 3; else if (stop_req) nx = 5; else if (wait_req) nx = 4;
      end
      else if (m_mode == 3) begin if (!dbg_req) nx = 2; end
      else if (m_mode == 4) begin if (dbg_req || (|(irq_pend & irq_mask))) nx = 6; end
      else if (m_mode == 5) begin
        if (dbg_req || can_wake || (|(irq_pend & irq_mask))) nx = 6;
      end
      else if (m_mode == 6) nx = 7;
      else nx = 2;
      m_pulse <= (m_mode == 1 && nx == 2);
      m_mode  <= nx;
      m_cfg   <= {c_dpwm, c_wwd, c_wpwm, c_swd, c_scan, c_pll};
    end
  end

  function automatic string tag_of(int m);
    case (m)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R6"; 5: return "R7"; default: return "R10";
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    bit [12:0] act, exp;
    if (!done) begin
      act = {core_rst, periph_rst, core_clk_en, mem_clk_en, periph_clk_en, wdog_en,
             pwm_dis, can_clk_en, pll_off, sync_pulse, mode_o};
      exp = expect_vec(m_mode, m_cfg, m_pulse);
      check(act == exp, tag_of(m_mode), int'(act), int'(exp));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wait();  wait_req = 1; step(1); wait_req = 0; endtask
  task automatic pulse_stop();  stop_req = 1; step(1); stop_req = 0; endtask

  initial begin
    step(3);
    rst = 0;
    step(1);
    // R1: reset state
    check(mode_o == 3'd0 && core_rst && periph_rst && !core_clk_en && !mem_clk_en &&
          !periph_clk_en && pwm_dis && !pll_off, "R1", mode_o, 0);
    sys_rst_req = 0;
    step(6);
    // R3: held in core-only reset while flash not done
    check(mode_o == 3'd1 && core_rst && !periph_rst && periph_clk_en, "R3", mode_o, 1);
    flash_done = 1;
    step(1);
    check(mode_o == 3'd2 && sync_pulse, "R4", {sync_pulse, mode_o}, 4'hA);
    step(1);
    check(!sync_pulse, "R4", sync_pulse, 0);
    // R5: debug wins over simultaneous wait and stop
    c_dpwm = 1; dbg_req = 1; wait_req = 1; stop_req = 1;
    step(1);
    wait_req = 0; stop_req = 0;
    check(mode_o == 3'd3 && !wdog_en && pwm_dis, "R5", mode_o, 3);
    step(2); dbg_req = 0; step(2);
    // R6: wait with options; CAN wake and masked irq ignored (R9)
    c_wwd = 1; c_wpwm = 1;
    pulse_wait();
    check(mode_o == 3'd4 && !wdog_en && pwm_dis && !core_clk_en, "R6", mode_o, 4);
    can_wake = 1; irq_pend = 8'h10; irq_mask = 8'hEF;
    step(3);
    check(mode_o == 3'd4, "R9", mode_o, 4);
    can_wake = 0; irq_mask = 8'h10;
    step(1);
    irq_pend = 0;
    check(mode_o == 3'd6 && mem_clk_en && !core_clk_en, "R10", mode_o, 6);
    step(1);
    check(mode_o == 3'd7 && core_clk_en, "R10", mode_o, 7);
    step(1);
    check(mode_o == 3'd2, "R10", mode_o, 2);
    // R7/R8: stop without PLL power-down, masked irq ignored, CAN wakes
    c_swd = 1; c_scan = 0; c_pll = 0;
    pulse_stop();
    check(mode_o == 3'd5 && !pll_off && !periph_clk_en && can_clk_en && !wdog_en,
          "R8", mode_o, 5);
    irq_pend = 8'h01; irq_mask = 8'h02;
    step(3);
    check(mode_o == 3'd5, "R9", mode_o, 5);
    irq_pend = 0; can_wake = 1; step(1); can_wake = 0;
    check(mode_o == 3'd6, "R9", mode_o, 6);
    step(3);
    // stop with PLL power-down and CAN stopped; debug wakes
    c_pll = 1; c_scan = 1; c_swd = 0;
    pulse_stop();
    check(pll_off && !can_clk_en && wdog_en, "R8", pll_off, 1);
    dbg_req = 1; step(1); dbg_req = 0;
    check(mode_o == 3'd6 && !pll_off, "R9", mode_o, 6);
    step(4);
    // R6: stop beats wait
    stop_req = 1; wait_req = 1; step(1); stop_req = 0; wait_req = 0;
    check(mode_o == 3'd5, "R6", mode_o, 5);
    irq_pend = 8'h80; irq_mask = 8'h80; step(1); irq_pend = 0;
    step(3);
    // R3: core-only request from run holds even with flash done
    core_rst_req = 1; step(3);
    check(mode_o == 3'd1 && core_rst && !periph_rst, "R3", mode_o, 1);
    core_rst_req = 0; step(2);
    // R2: system reset from stop
    pulse_stop();
    sys_rst_req = 1; step(1);
    check(mode_o == 3'd0 && core_rst && periph_rst, "R2", mode_o, 0);
    sys_rst_req = 0; step(1);
    check(mode_o == 3'd1, "R2", mode_o, 1);
    step(3);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule